// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four reset requests into a single system reset and keeps a record of which request started the most recent reset. The requests are an active-low external reset input, a trip signal from a missing-clock detector, the output of an analog comparator (a low output asks for reset), and an expiry pulse from a watchdog counter. A byte-wide register gives software the cause of the last reset on reads. On writes it turns the optional sources on and off. An enable bit sits at the same bit position as the cause flag of its source.

A low-power input models the suspend and sleep states. While it is high, the missing-clock and watchdog requests are masked. The comparator request is kept only when the comparator is also armed as a wake-up source. The external input is never masked. Low power never changes the stored enables, so each source comes back in its earlier state on wake. The block drives two outputs. The first is an immediate request that follows the inputs combinationally, so the external input asserts reset asynchronously. The second is a stretched reset that is held for a set number of clock cycles after the last request clears, and that is released on a clock edge.

Top module: `rstHub`

## Requirements
- R1: A low level on `extRstN` drives `rstReq` and `rstOut` high in the same cycle, whatever the state of `lowPower` and of the enables.
- R2: `extRstN` passes through a two-stage synchronizer before it can record a cause. A reset caused by the external input reads back as 0x01 (bit 0).
- R3: Writing bit 2 of the register sets (1) or clears (0) the missing-clock enable. With the enable set and `lowPower` low, a high `mcdTrip` causes a reset that reads back as 0x04. With the enable clear, `mcdTrip` has no effect.
- R4: Writing bit 5 sets or clears the comparator enable. With the enable set, a low `cmpOut` causes a reset that reads back as 0x20.
- R5: While `lowPower` is high, the comparator request acts only if `cmpWakeEn` is also high.
- R6: A high `wdtExpire` while `lowPower` is low causes a reset that reads back as 0x08 (bit 3). Bit 3 cannot be written.
- R7: While `lowPower` is high, `mcdTrip` and `wdtExpire` are masked. Once `lowPower` returns low, the missing-clock enable acts as it did before.
- R8: `rstOut` stays high until STRETCH_CYCLES rising edges have passed after the last edge that sampled a request, and it falls on a rising edge. For a one-cycle watchdog pulse this gives STRETCH_CYCLES falling-edge samples; after the external input is released it gives STRETCH_CYCLES+2.
- R9: When a reset begins (the stretch counter is idle), the flags are replaced by the single flag of the winning source. The priority is external > missing-clock > comparator > watchdog. Requests that arrive while a reset is already under way leave the flags as they are.
- R10: Bits 1, 4, 6 and 7 always read 0. Bits 2 and 5 read the cause flags, not the enables. Register writes never change what is read.
- R11: Power-on reset (`porN` low) clears all flags and both enables. Afterwards, with idle inputs, `rstOut` is low and `mcdTrip` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| extRstN | input | 1 | External reset request, active low |
| mcdTrip | input | 1 | Missing-clock detector trip |
| cmpOut | input | 1 | Comparator output; low requests reset |
| cmpWakeEn | input | 1 | Comparator is armed as a wake-up source |
| wdtExpire | input | 1 | Watchdog expiry |
| lowPower | input | 1 | Suspend/sleep state |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (cause flags) |
| rstReq | output | 1 | Immediate combined reset request |
| rstOut | output | 1 | Stretched system reset |

## Verification
`rstReq` follows the inputs within the same cycle. The bench therefore reads it 1 ns after driving an input on a falling edge. Flags from missing-clock, comparator and watchdog requests are loaded on the first rising edge that sees the request, and the bench reads them at the next falling edge. A flag from the external input is loaded on the third rising edge after the input falls, so the bench waits three falling edges before reading it. Stretch lengths are measured by counting, from the release point, the falling edges at which `rstOut` is still high. In the random phase a cycle-level model built from the requirements updates on every rising edge, and its results are compared at the following falling edge.

// File: rtl/rstHubPkg.sv
package rstHubPkg;
  // Register bit positions shared by cause flags and enables
  localparam int PIN_BIT = 0;
  localparam int MCD_BIT = 2;
  localparam int WDT_BIT = 3;
  localparam int CMP_BIT = 5;

  typedef struct packed {
    logic wdt;
    logic cmp;
    logic mcd;
    logic pin;
  } srcVec_t;

  typedef struct packed {
    logic capture;   // a reset begins on this edge
    logic cfgWrite;  // enables take the write data
  } hubStrobe_t;
endpackage

// File: rtl/rstHubCtrl.sv
module rstHubCtrl
  import rstHubPkg::*;
#(
  parameter int STRETCH_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       extRstN,
  input  logic       regWrEn,
  input  srcVec_t    gatedReq,
  output logic       pinSync,
  output logic       pinPending,
  output logic       stretchActive,
  output hubStrobe_t strobe
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STRETCH_CYCLES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       holdCnt;
  logic                   anyReq;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncChain <= '0;
    end else begin
      syncChain[0] <= ~extRstN;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign pinSync    = syncChain[SYNC_STAGES-1];
  assign pinPending = |syncChain;

  assign anyReq = |gatedReq;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      holdCnt <= '0;
    end else if (anyReq) begin
      holdCnt <= LOAD_VAL;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - CNT_W'(1);
    end
  end

  assign stretchActive   = (holdCnt != '0);
  assign strobe.capture  = anyReq && (holdCnt == '0);
  assign strobe.cfgWrite = regWrEn;
endmodule

// File: rtl/rstHubPath.sv
module rstHubPath
  import rstHubPkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  hubStrobe_t       strobe,
  input  logic             pinSync,
  input  logic             mcdTrip,
  input  logic             cmpOut,
  input  logic             cmpWakeEn,
  input  logic             wdtExpire,
  input  logic             lowPower,
  input  logic             wrMcdEn,
  input  logic             wrCmpEn,
  output srcVec_t          gatedReq,
  output logic             liveReq,
  output logic [REG_W-1:0] regRdData
);
  logic    mcdEn;
  logic    cmpEn;
  srcVec_t causeFlags;
  srcVec_t winner;

  // Masking leaves the stored enables untouched, so wake restores them
  always_comb begin
    gatedReq.pin = pinSync;
    gatedReq.mcd = mcdEn & mcdTrip & ~lowPower;
    gatedReq.cmp = cmpEn & ~cmpOut & (~lowPower | cmpWakeEn);
    gatedReq.wdt = wdtExpire & ~lowPower;
  end

  assign liveReq = gatedReq.mcd | gatedReq.cmp | gatedReq.wdt;

  always_comb begin
    winner = '0;
    if (gatedReq.pin)      winner.pin = 1'b1;
    else if (gatedReq.mcd) winner.mcd = 1'b1;
    else if (gatedReq.cmp) winner.cmp = 1'b1;
    else if (gatedReq.wdt) winner.wdt = 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      mcdEn <= 1'b0;
      cmpEn <= 1'b0;
    end else if (strobe.cfgWrite) begin
      mcdEn <= wrMcdEn;
      cmpEn <= wrCmpEn;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      causeFlags <= '0;
    end else if (strobe.capture) begin
      causeFlags <= winner;
    end
  end

  always_comb begin
    regRdData          = '0;
    regRdData[PIN_BIT] = causeFlags.pin;
    regRdData[MCD_BIT] = causeFlags.mcd;
    regRdData[WDT_BIT] = causeFlags.wdt;
    regRdData[CMP_BIT] = causeFlags.cmp;
  end
endmodule

// File: rtl/rstHub.sv
module rstHub
  import rstHubPkg::*;
#(
  parameter int STRETCH_CYCLES = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int REG_W          = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             extRstN,
  input  logic             mcdTrip,
  input  logic             cmpOut,
  input  logic             cmpWakeEn,
  input  logic             wdtExpire,
  input  logic             lowPower,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             rstReq,
  output logic             rstOut
);
  hubStrobe_t strobe;
  srcVec_t    gatedReq;
  logic       pinSync;
  logic       pinPending;
  logic       stretchActive;
  logic       liveReq;
  logic       unusedWrBits;

  assign unusedWrBits = ^regWrData;

  rstHubCtrl #(
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) uCtrl (
    .clk          (clk),
    .porN         (porN),
    .extRstN      (extRstN),
    .regWrEn      (regWrEn),
    .gatedReq     (gatedReq),
    .pinSync      (pinSync),
    .pinPending   (pinPending),
    .stretchActive(stretchActive),
    .strobe       (strobe)
  );

  rstHubPath #(
    .REG_W(REG_W)
  ) uPath (
    .clk      (clk),
    .porN     (porN),
    .strobe   (strobe),
    .pinSync  (pinSync),
    .mcdTrip  (mcdTrip),
    .cmpOut   (cmpOut),
    .cmpWakeEn(cmpWakeEn),
    .wdtExpire(wdtExpire),
    .lowPower (lowPower),
    .wrMcdEn  (regWrData[MCD_BIT]),
    .wrCmpEn  (regWrData[CMP_BIT]),
    .gatedReq (gatedReq),
    .liveReq  (liveReq),
    .regRdData(regRdData)
  );

  // External input asserts asynchronously; release waits for the counter
  assign rstReq = ~extRstN | liveReq;
  assign rstOut = rstReq | pinPending | stretchActive;
endmodule

// File: rtl/rstHubChk.sv
module rstHubChk (
  input logic       clk,
  input logic       porN,
  input logic       extRstN,
  input logic       lowPower,
  input logic       cmpWakeEn,
  input logic [7:0] regRdData,
  input logic       rstReq,
  input logic       rstOut
);
  // R1
  pin_forces_rst_chk: assert property (@(posedge clk) disable iff (!porN)
    !extRstN |-> (rstReq && rstOut));

  // R5
  sleep_mask_chk: assert property (@(posedge clk) disable iff (!porN)
    (lowPower && !cmpWakeEn && extRstN) |-> !rstReq);

  // R8
  req_holds_rst_chk: assert property (@(posedge clk) disable iff (!porN)
    rstReq |=> rstOut);

  // R9
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!porN)
    $onehot0(regRdData));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!porN)
    (regRdData & 8'hD2) == 8'h00);

  // R10
  quiet_flags_stable_chk: assert property (@(posedge clk) disable iff (!porN)
    !rstOut |=> $stable(regRdData));
endmodule

bind rstHub rstHubChk uChk (
  .clk      (clk),
  .porN     (porN),
  .extRstN  (extRstN),
  .lowPower (lowPower),
  .cmpWakeEn(cmpWakeEn),
  .regRdData(regRdData),
  .rstReq   (rstReq),
  .rstOut   (rstOut)
);

// File: tb/rstHub_test.sv
`timescale 1ns/1ps
module rstHub_test;
  localparam int S = 16;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       extRstN = 1'b1;
  logic       mcdTrip = 1'b0;
  logic       cmpOut = 1'b1;
  logic       cmpWakeEn = 1'b0;
  logic       wdtExpire = 1'b0;
  logic       lowPower = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       rstReq;
  logic       rstOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rstHub #(.STRETCH_CYCLES(S)) uut (
    .clk(clk), .porN(porN), .extRstN(extRstN), .mcdTrip(mcdTrip),
    .cmpOut(cmpOut), .cmpWakeEn(cmpWakeEn), .wdtExpire(wdtExpire),
    .lowPower(lowPower), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rstReq(rstReq), .rstOut(rstOut)
  );

  // Requirement-level model: {wdt, cmp, mcd, pin} -> register image
  function automatic logic [7:0] prio(input logic [3:0] r);
    if (r[0]) return 8'h01;
    if (r[1]) return 8'h04;
    if (r[2]) return 8'h20;
    if (r[3]) return 8'h08;
    return 8'h00;
  endfunction

  function automatic logic [3:0] gatedNow(input logic mEnM, input logic mEnC, input logic s2);
    logic [3:0] g;
    g[0] = s2;
    g[1] = mEnM & mcdTrip & ~lowPower;
    g[2] = mEnC & ~cmpOut & (~lowPower | cmpWakeEn);
    g[3] = wdtExpire & ~lowPower;
    return g;
  endfunction

  logic       mS1, mS2, mMcdEn, mCmpEn;
  int         mCnt;
  logic [7:0] mFlags;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mS1 = 0; mS2 = 0; mCnt = 0; mFlags = 0; mMcdEn = 0; mCmpEn = 0;
    end else begin
      logic [3:0] req;
      req = gatedNow(mMcdEn, mCmpEn, mS2);
      if (req != 4'b0) begin
        if (mCnt == 0) mFlags = prio(req);
        mCnt = S;
      end else if (mCnt != 0) begin
        mCnt = mCnt - 1;
      end
      mS2 = mS1;
      mS1 = ~extRstN;
      if (regWrEn) begin
        mMcdEn = regWrData[2];
        mCmpEn = regWrData[5];
      end
    end
  end

  function automatic logic expRst();
    logic [3:0] g;
    g = gatedNow(mMcdEn, mCmpEn, 1'b0);
    return ~extRstN | mS1 | mS2 | (mCnt != 0) | (|g);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wrReg(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitQuiet();
    for (int i = 0; i < 200 && rstOut; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    #1;
    while (rstOut && n < 500) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    chk("R11 flags after por", regRdData, 8'h00);
    chk("R11 rstOut idle", {7'b0, rstOut}, 8'h01 & 8'h00);
    mcdTrip = 1'b1; #1;
    chk("R11 mcd disabled at por", {7'b0, rstReq}, 8'h00);
    @(negedge clk); mcdTrip = 1'b0;
    @(negedge clk);

    // R1 / R2: external input, during low power
    lowPower = 1'b1;
    extRstN = 1'b0; #1;
    chk("R1 rstReq immediate", {7'b0, rstReq}, 8'h01);
    chk("R1 rstOut immediate", {7'b0, rstOut}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R2 pin cause", regRdData, 8'h01);
    lowPower = 1'b0;
    extRstN = 1'b1;
    measure(n);
    chk("R8 stretch after pin", 8'(n), 8'(S + 2));
    @(negedge clk);

    // R6 / R8: watchdog pulse
    wdtExpire = 1'b1;
    @(negedge clk); wdtExpire = 1'b0;
    measure(n);
    chk("R8 stretch after wdt", 8'(n), 8'(S));
    chk("R6 wdt cause", regRdData, 8'h08);
    @(negedge clk);
    wrReg(8'hFF);
    chk("R10 write leaves read", regRdData, 8'h08);

    // R3: missing clock enabled by the write above
    mcdTrip = 1'b1;
    @(negedge clk); mcdTrip = 1'b0;
    chk("R3 mcd cause", regRdData, 8'h04);
    waitQuiet();
    wrReg(8'h20);
    mcdTrip = 1'b1; #1;
    chk("R3 mcd disabled no req", {7'b0, rstReq}, 8'h00);
    @(negedge clk); mcdTrip = 1'b0;
    chk("R3 flags kept when disabled", regRdData, 8'h04);
    chk("R3 no rstOut when disabled", {7'b0, rstOut}, 8'h00);

    // R4: comparator
    cmpOut = 1'b0; #1;
    chk("R4 cmp req", {7'b0, rstReq}, 8'h01);
    @(negedge clk); cmpOut = 1'b1;
    chk("R4 cmp cause", regRdData, 8'h20);
    waitQuiet();

    // R9: requests during an ongoing reset keep the flags
    wdtExpire = 1'b1;
    @(negedge clk); wdtExpire = 1'b0;
    cmpOut = 1'b0;
    @(negedge clk); cmpOut = 1'b1;
    chk("R9 flags held mid-reset", regRdData, 8'h08);
    waitQuiet();

    // R5: comparator in low power
    lowPower = 1'b1; cmpWakeEn = 1'b0; cmpOut = 1'b0; #1;
    chk("R5 cmp masked asleep", {7'b0, rstReq}, 8'h00);
    @(negedge clk);
    chk("R5 no rstOut asleep", {7'b0, rstOut}, 8'h00);
    chk("R5 flags unchanged", regRdData, 8'h08);
    cmpWakeEn = 1'b1; #1;
    chk("R5 cmp live with wake", {7'b0, rstReq}, 8'h01);
    @(negedge clk); cmpOut = 1'b1;
    chk("R5 cmp cause asleep", regRdData, 8'h20);
    waitQuiet();

    // R7: mask in low power, enable restored on wake
    wrReg(8'h24);
    mcdTrip = 1'b1; wdtExpire = 1'b1; #1;
    chk("R7 mcd/wdt masked", {7'b0, rstReq}, 8'h00);
    @(negedge clk);
    chk("R7 flags unchanged asleep", regRdData, 8'h20);
    mcdTrip = 1'b0; wdtExpire = 1'b0; lowPower = 1'b0; cmpWakeEn = 1'b0;
    @(negedge clk);
    mcdTrip = 1'b1;
    @(negedge clk); mcdTrip = 1'b0;
    chk("R7 mcd restored on wake", regRdData, 8'h04);
    waitQuiet();

    // R9: priority
    cmpOut = 1'b0; wdtExpire = 1'b1; mcdTrip = 1'b1;
    @(negedge clk); cmpOut = 1'b1; wdtExpire = 1'b0; mcdTrip = 1'b0;
    chk("R9 mcd over cmp and wdt", regRdData, 8'h04);
    waitQuiet();
    cmpOut = 1'b0; wdtExpire = 1'b1;
    @(negedge clk); cmpOut = 1'b1; wdtExpire = 1'b0;
    chk("R9 cmp over wdt", regRdData, 8'h20);
    waitQuiet();
    extRstN = 1'b0;
    repeat (2) @(negedge clk);
    cmpOut = 1'b0; wdtExpire = 1'b1; mcdTrip = 1'b1;
    @(negedge clk); cmpOut = 1'b1; wdtExpire = 1'b0; mcdTrip = 1'b0;
    chk("R9 pin over all", regRdData, 8'h01);
    extRstN = 1'b1;
    waitQuiet();

    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      chk("R9 random flags", regRdData, mFlags);
      chk("R8 random rstOut", {7'b0, rstOut}, {7'b0, expRst()});
      extRstN   = ($urandom_range(99) >= 2);
      mcdTrip   = ($urandom_range(99) < 4);
      cmpOut    = !($urandom_range(99) < 4);
      wdtExpire = ($urandom_range(99) < 3);
      if ($urandom_range(99) < 3) lowPower = ~lowPower;
      if ($urandom_range(99) < 5) cmpWakeEn = ~cmpWakeEn;
      regWrEn   = ($urandom_range(99) < 5);
      regWrData = 8'($urandom);
      #1;
      chk("R1 random rstReq", {7'b0, rstReq},
          {7'b0, ~extRstN | (|gatedNow(mMcdEn, mCmpEn, 1'b0))});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule